// File: doc/BRIEF.md
# DMA Error Status Monitor

This block watches a DMA channel controller for two kinds of fault and latches each one into a sticky status bit. The first kind is a queue that has grown too deep. The current event depth of each event queue is compared against a programmable watermark, and the queue's flag is set once the depth reaches that watermark. The second kind is too many outstanding completion codes. An internal counter tracks transfer requests that asked for a completion code to be returned. The counter rises when such a request is issued and falls when a completion comes back. A dedicated flag is set once the counter reaches its ceiling of 63.

Software sees the flags through a read-only status word at one address and clears them at another address. Each 1 written to the clear address clears the flag at that bit position. The watermarks are kept in a third, writable register. The block also produces a one-cycle error interrupt, but only when the whole controller goes from error-free to faulted. "Error-free" here includes a level input that reports errors held in registers outside this block.

Top module: `dmaerr_monitor`

## Requirements
- R1: A queue flag is set when that queue's depth is greater than or equal to its nonzero watermark. Queue 0 reports at status bit 0 and queue 1 at status bit 1, and the flag shows in the status word one cycle after the depth is applied.
- R2: A watermark of zero turns off the check for its queue, so its flag is never set by depth.
- R3: A request counts as outstanding only when `xfer_issue` is high together with `xfer_intr_en` or `xfer_chain_en`. Issues with both enables low leave the count unchanged.
- R4: The outstanding count saturates at 63 and never goes below 0. An issue and a completion in the same cycle leave it unchanged.
- R5: The completion-code flag, at status bit 16, is set once the outstanding count equals 63.
- R6: Every flag is sticky. Once set, it stays set after its cause goes away, until it is cleared.
- R7: A write to address 1 clears each flag whose bit in the write data is 1. Bits written as 0 have no effect, and writes to the status address (0) change nothing.
- R8: If a flag's condition is present in the same cycle as a clear of that flag, the flag stays 1.
- R9: `err_irq` is a single-cycle pulse. It rises in the same cycle as a flag that has just been set, provided all status bits were 0 and `ext_err` was low in the cycle before.
- R10: No interrupt is raised while `ext_err` is high or while any status bit is already set.
- R11: Reset clears all flags and the interrupt. Status bits 15:2 and 31:17 always read 0.
- R12: Read data is registered and appears one cycle after the address. Address 0 gives status, address 1 reads 0, and address 2 holds the watermarks, with queue 0 at bits 4:0 and queue 1 at bits 12:8. Both watermarks reset to 0, and a write to address 2 takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_depth | input | NQ*DEPTH_W | Current depth of each event queue, queue 0 in the low lane |
| xfer_issue | input | 1 | A transfer request is issued this cycle |
| xfer_intr_en | input | 1 | The issued request asks for a completion interrupt |
| xfer_chain_en | input | 1 | The issued request asks for a completion chain |
| xfer_done | input | 1 | A completion code returns this cycle |
| ext_err | input | 1 | Level: errors are pending in registers outside this block |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| err_irq | output | 1 | One-cycle error interrupt pulse |

## Verification
The bench drives depth exactly at the watermark and one below it, and writes a zero watermark with the depth at its maximum. An off-by-one compare would flag early or late, and a missing disable would flag a queue that was turned off. It pushes the outstanding count past 63 and back, and drains it below zero. It also counts issues that have neither enable set. A counter that wrapped, underflowed or counted unqualified requests would then raise or drop bit 16 at the wrong time. Clears are written with zero bits, to the wrong address and in the same cycle as a live condition, to catch a design that lost a flag. Flags are set both while `ext_err` is high and while another flag is already set, to catch an interrupt that fires on every new bit rather than on the move from clean to faulted.

// File: rtl/dmaerr_pkg.sv
package dmaerr_pkg;
  localparam int REG_W   = 32;
  // register word addresses
  localparam int A_STAT  = 0;
  localparam int A_CLR   = 1;
  localparam int A_WM    = 2;
  // status bit of the completion-code flag
  localparam int TCC_BIT = 16;
  // lane spacing of the watermark fields
  localparam int WM_LANE = 8;
endpackage

// File: rtl/qdepth_watch.sv
module qdepth_watch #(
  parameter int DEPTH_W = 5,
  parameter int WM_W    = 5
) (
  input  logic [DEPTH_W-1:0] depth,
  input  logic [WM_W-1:0]    wmark,
  output logic               hit
);
  localparam int CMP_W = (DEPTH_W > WM_W) ? DEPTH_W : WM_W;

  logic [CMP_W-1:0] depth_x, wmark_x;

  always_comb begin
    depth_x = CMP_W'(depth);
    wmark_x = CMP_W'(wmark);
    // a zero watermark turns the check off
    hit     = (wmark != '0) && (depth_x >= wmark_x);
  end
endmodule

// File: rtl/tcc_tracker.sv
module tcc_tracker #(
  parameter int LIMIT = 63
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic done,
  output logic at_limit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (issue && !done) begin
      if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
    end else if (done && !issue) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign at_limit = (cnt_q == CW'(LIMIT));

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(LIMIT) && issue && !done) |=> (cnt_q == CW'(LIMIT))); // R4
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && done && !issue) |=> (cnt_q == '0)); // R4
  AST_CNT_NET_ZERO: assert property (@(posedge clk) disable iff (rst)
    (issue && done) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/err_status.sv
module err_status #(
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] cond,
  input  logic [NB-1:0] clr,
  input  logic          ext_err,
  output logic [NB-1:0] status,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr) | cond;
      irq    <= (|cond) && (status == '0) && !ext_err;
    end
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|(status & ~clr)) |=> ((status & $past(status & ~clr)) == $past(status & ~clr))); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|cond) |=> ((status & $past(cond)) == $past(cond))); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R9
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|status)); // R9
  AST_IRQ_EXT_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(ext_err) |-> !irq); // R10
endmodule

// File: rtl/dmaerr_monitor.sv
module dmaerr_monitor
  import dmaerr_pkg::*;
#(
  parameter int NQ      = 2,
  parameter int DEPTH_W = 5,
  parameter int WM_W    = 5,
  parameter int TCC_MAX = 63,
  parameter int ADDR_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NQ*DEPTH_W-1:0] q_depth,
  input  logic                  xfer_issue,
  input  logic                  xfer_intr_en,
  input  logic                  xfer_chain_en,
  input  logic                  xfer_done,
  input  logic                  ext_err,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_we,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic                  err_irq
);
  localparam int NB = NQ + 1;

  logic [WM_W-1:0]  wm_q [NQ];
  logic [NB-1:0]    cond, clr_mask, status;
  logic [REG_W-1:0] stat_word, wm_word;
  logic             wr_clr, wr_wm, tcc_issue;
  logic             wdata_unused;

  assign wr_clr       = reg_we && (reg_addr == ADDR_W'(A_CLR));
  assign wr_wm        = reg_we && (reg_addr == ADDR_W'(A_WM));
  assign tcc_issue    = xfer_issue && (xfer_intr_en || xfer_chain_en);
  assign wdata_unused = ^reg_wdata;

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    always_ff @(posedge clk) begin
      if (rst)        wm_q[q] <= '0;
      else if (wr_wm) wm_q[q] <= reg_wdata[q*WM_LANE +: WM_W];
    end

    qdepth_watch #(.DEPTH_W(DEPTH_W), .WM_W(WM_W)) u_watch (
      .depth (q_depth[q*DEPTH_W +: DEPTH_W]),
      .wmark (wm_q[q]),
      .hit   (cond[q])
    );

    assign clr_mask[q] = wr_clr && reg_wdata[q];
  end

  tcc_tracker #(.LIMIT(TCC_MAX)) u_tcc (
    .clk      (clk),
    .rst      (rst),
    .issue    (tcc_issue),
    .done     (xfer_done),
    .at_limit (cond[NQ])
  );

  assign clr_mask[NQ] = wr_clr && reg_wdata[TCC_BIT];

  err_status #(.NB(NB)) u_status (
    .clk     (clk),
    .rst     (rst),
    .cond    (cond),
    .clr     (clr_mask),
    .ext_err (ext_err),
    .status  (status),
    .irq     (err_irq)
  );

  always_comb begin
    stat_word = '0;
    wm_word   = '0;
    for (int q = 0; q < NQ; q++) begin
      stat_word[q]                 = status[q];
      wm_word[q*WM_LANE +: WM_W]   = wm_q[q];
    end
    stat_word[TCC_BIT] = status[NQ];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADDR_W'(A_STAT): reg_rdata <= stat_word;
        ADDR_W'(A_WM):   reg_rdata <= wm_word;
        default:         reg_rdata <= '0;
      endcase
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == ADDR_W'(A_STAT)) |->
      (reg_rdata[TCC_BIT-1:NQ] == '0 && reg_rdata[REG_W-1:TCC_BIT+1] == '0)); // R11
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == ADDR_W'(A_CLR)) |-> (reg_rdata == '0)); // R12
endmodule

// File: tb/dmaerr_monitor_test.sv
module dmaerr_monitor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  q_depth;
  logic        xfer_issue, xfer_intr_en, xfer_chain_en, xfer_done, ext_err;
  logic [3:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata, reg_rdata;
  logic        err_irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [2:0] m_stat;
  int         m_cnt;
  logic [4:0] m_wm0, m_wm1;

  always #5 clk = ~clk;

  dmaerr_monitor uut (
    .clk(clk), .rst(rst), .q_depth(q_depth),
    .xfer_issue(xfer_issue), .xfer_intr_en(xfer_intr_en),
    .xfer_chain_en(xfer_chain_en), .xfer_done(xfer_done),
    .ext_err(ext_err), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_irq(err_irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_word(logic [2:0] s);
    return {15'd0, s[2], 14'd0, s[1], s[0]};
  endfunction

  task automatic idle();
    q_depth = '0; xfer_issue = 0; xfer_intr_en = 0; xfer_chain_en = 0;
    xfer_done = 0; ext_err = 0; reg_addr = '0; reg_we = 0; reg_wdata = '0;
  endtask

  // one clock with model prediction; inputs already driven
  task automatic step();
    logic [2:0]  cond, clr;
    logic [31:0] exp_rd;
    logic        exp_irq, qi;
    cond[0] = (m_wm0 != 0) && (q_depth[4:0] >= m_wm0);
    cond[1] = (m_wm1 != 0) && (q_depth[9:5] >= m_wm1);
    cond[2] = (m_cnt == 63);
    clr     = (reg_we && reg_addr == 4'd1) ? {reg_wdata[16], reg_wdata[1:0]} : 3'b000;
    exp_irq = (|cond) && (m_stat == 3'b000) && !ext_err;
    case (reg_addr)
      4'd0:    exp_rd = stat_word(m_stat);
      4'd2:    exp_rd = {19'd0, m_wm1, 3'd0, m_wm0};
      default: exp_rd = 32'd0;
    endcase
    @(posedge clk);
    m_stat = (m_stat & ~clr) | cond;
    if (reg_we && reg_addr == 4'd2) begin
      m_wm0 = reg_wdata[4:0];
      m_wm1 = reg_wdata[12:8];
    end
    qi = xfer_issue && (xfer_intr_en || xfer_chain_en);
    if (qi && !xfer_done && m_cnt < 63) m_cnt++;
    else if (xfer_done && !qi && m_cnt > 0) m_cnt--;
    @(negedge clk);
    chk("R9 irq", {31'd0, err_irq}, {31'd0, exp_irq});
    chk("R12 rdata", reg_rdata, exp_rd);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    idle(); reg_we = 1; reg_addr = a; reg_wdata = d; step(); idle();
  endtask

  task automatic rd(logic [3:0] a);
    idle(); reg_addr = a; step();
  endtask

  task automatic issue_n(int n, bit ie, bit ce);
    for (int i = 0; i < n; i++) begin
      idle(); xfer_issue = 1; xfer_intr_en = ie; xfer_chain_en = ce; step();
    end
    idle();
  endtask

  task automatic done_n(int n);
    for (int i = 0; i < n; i++) begin
      idle(); xfer_done = 1; step();
    end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    m_stat = '0; m_cnt = 0; m_wm0 = '0; m_wm1 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R11 reset state
    rd(4'd0);
    chk("R11 reset status", reg_rdata, 32'd0);
    chk("R11 reset irq", {31'd0, err_irq}, 32'd0);

    // R12 watermark register
    wr(4'd2, 32'h0000_0804);
    rd(4'd2);
    chk("R12 wm readback", reg_rdata, 32'h0000_0804);

    // R1 compare boundary on queue 0
    idle(); q_depth = 10'd3; step();
    chk("R1 below wm no irq", {31'd0, err_irq}, 32'd0);
    idle(); q_depth = 10'd4; step();
    chk("R9 irq on first error", {31'd0, err_irq}, 32'd1);
    rd(4'd0);
    chk("R1 q0 flag", reg_rdata, 32'h1);
    chk("R9 pulse ends", {31'd0, err_irq}, 32'd0);

    // R10 second flag while one set: no irq
    idle(); q_depth = {5'd8, 5'd0}; step();
    chk("R10 no irq when status set", {31'd0, err_irq}, 32'd0);
    rd(4'd0);
    chk("R1 q1 flag bit1", reg_rdata, 32'h3);

    // R6 sticky, R7 write-one-to-clear
    wr(4'd1, 32'h0);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0);
    chk("R7 zero write / status write ignored", reg_rdata, 32'h3);
    chk("R6 sticky after cause gone", reg_rdata[1:0], 32'h3);
    wr(4'd1, 32'h1);
    rd(4'd0);
    chk("R7 clear bit0", reg_rdata, 32'h2);
    wr(4'd1, 32'h2);
    rd(4'd0);
    chk("R7 clear bit1", reg_rdata, 32'h0);

    // R8 set wins over clear
    idle(); q_depth = 10'd5; step();
    idle(); q_depth = 10'd5; reg_we = 1; reg_addr = 4'd1; reg_wdata = 32'h1; step();
    rd(4'd0);
    chk("R8 set wins", reg_rdata, 32'h1);
    wr(4'd1, 32'h1);

    // R10 external errors block irq
    idle(); ext_err = 1; q_depth = {5'd9, 5'd0}; step();
    chk("R10 ext_err blocks irq", {31'd0, err_irq}, 32'd0);
    wr(4'd1, 32'h2);

    // R2 zero watermark disables
    wr(4'd2, 32'h0000_0800);
    idle(); q_depth = 10'd31; step();
    rd(4'd0);
    chk("R2 disabled queue", reg_rdata, 32'h0);

    // R3 unqualified issues ignored, R5 limit flag
    issue_n(70, 0, 0);
    issue_n(62, 1, 0);
    rd(4'd0);
    chk("R3 unqualified not counted", reg_rdata, 32'h0);
    issue_n(1, 0, 1);
    idle(); step();
    rd(4'd0);
    chk("R5 tcc flag bit16", reg_rdata, 32'h0001_0000);

    // R4 saturation
    issue_n(10, 1, 1);
    done_n(1);
    wr(4'd1, 32'h0001_0000);
    rd(4'd0);
    chk("R4 below limit after done", reg_rdata, 32'h0);
    issue_n(1, 1, 0);
    idle(); step();
    rd(4'd0);
    chk("R4 saturated at 63", reg_rdata, 32'h0001_0000);
    idle(); xfer_issue = 1; xfer_intr_en = 1; xfer_done = 1; step();
    // R4 floor at zero
    done_n(70);
    wr(4'd1, 32'h0001_0000);
    issue_n(62, 1, 0);
    idle(); step();
    rd(4'd0);
    chk("R4 floor no underflow", reg_rdata, 32'h0);
    issue_n(1, 1, 0);
    idle(); step();
    rd(4'd0);
    chk("R4 R5 reaches limit again", reg_rdata, 32'h0001_0000);
    done_n(64);
    wr(4'd1, 32'h0001_0003);
    wr(4'd2, 32'h0000_0a06);

    // random phase, checked every cycle by the model
    for (int i = 0; i < 6000; i++) begin
      int mode;
      mode = (i / 500) % 3;
      idle();
      q_depth       = 10'($urandom);
      xfer_issue    = ($urandom % 4) < (mode == 0 ? 3 : 1);
      xfer_intr_en  = $urandom % 2;
      xfer_chain_en = $urandom % 2;
      xfer_done     = ($urandom % 4) < (mode == 2 ? 3 : 1);
      ext_err       = ($urandom % 8) == 0;
      reg_addr      = 4'($urandom % 4);
      reg_we        = ($urandom % 6) == 0;
      reg_wdata     = $urandom;
      if (reg_addr == 4'd1 && reg_we) reg_wdata = reg_wdata | 32'h0001_0003;
      step();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule